// File: doc/BRIEF.md
# SMI Event Status Collector

This block keeps a small bank of system-management status flags and drives an active-low SMI request while any of them is set. Each flag has its own set rule: a watchdog expiry pulse, writes to two data-port registers, a firmware write-protect violation, a year-rollover event that arrives from a slow real-time-clock domain, and a read-only mirror of an external redirected-NMI status. Software clears the flags by writing ones to a single status address on a simple register write port.

The write-protect check sees a flash write-attempt strobe with its address and a level pair, protect-enable and lock-down. A write attempt with protect-enable high sets the violation flag, except when the address falls in a 4 MB alias window that sits below the top firmware region. Raising protect-enable while lock-down is high also sets it. The century flag is owned by the slow clock domain. A clear request crosses over as a toggle through a two-flop synchronizer, and the flag's level crosses back through another two-flop synchronizer. A clear therefore takes effect only after a few slow clocks.

No port carries a data stream, so there is no valid/ready handshake and no back-pressure. The write port accepts a write on every core cycle in which its enable is high. All other pins are plain control and status levels or one-cycle pulses.

Top module: `smi_evt_collector`

## Requirements
- R1: After reset, `sts_q` reads 0x0000 and `smi_n` reads 1.
- R2: A one-cycle pulse on `wdt_zero`, `dout_wr` or `din_wr` sets status bit 3, 2 or 1 respectively. The bit stays set until a write to `STS_ADDR` has a 1 in that bit position. A write with a 0 there, or a write to any other address, leaves it set.
- R3: When a set event and a write-one-to-clear hit the same bit in the same core cycle, the bit ends up set.
- R4: Bit 8 (write violation) sets when `prot_en` goes from 0 to 1 while `lock_dn` is 1. The same rise with `lock_dn` at 0 does not set it, and `prot_en` held high does not set it again after a clear.
- R5: Bit 8 sets on a `fl_wr_stb` cycle with `prot_en` at 1 whose address lies outside the alias window. With `prot_en` at 0, a write attempt does not set it.
- R6: A write attempt whose address lies in [`ALIAS_BASE`, `ALIAS_BASE`+`ALIAS_SIZE`) never sets bit 8. The defaults are 0xFF80_0000 and 4 MB.
- R7: A one-slow-cycle pulse on `rtc_year_roll` sets bit 7 (century). The bit is visible in `sts_q` within three core cycles after the slow edge that captured the pulse.
- R8: After a core write with bit 7 set, bit 7 still reads 1 in the next core cycle. It reads 0 no later than three slow clocks plus three core clocks after the write.
- R9: Asserting `rtc_rst_n` low clears bit 7. It reads 0 within three core cycles.
- R10: Bit 0 is read-only and equals `nmi_redir_sts` as sampled at the previous core edge. Writing a 1 to bit 0 has no effect.
- R11: Bits 6:4 and 15:9 always read 0, even after a write of 0xFFFF.
- R12: `smi_n` is 0 in the core cycle after any status bit reads 1. It returns to 1 in the first core cycle after all status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Core asynchronous reset, active low |
| rtc_clk | input | 1 | Slow real-time-clock domain clock |
| rtc_rst_n | input | 1 | Slow-domain reset, active low; clears the century flag |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write address |
| reg_wr_data | input | 16 | Write data; ones clear the matching status bits |
| prot_en | input | 1 | Firmware write-protect enable level |
| lock_dn | input | 1 | Write-protect lock-down level |
| fl_wr_stb | input | 1 | Firmware-space write-attempt strobe |
| fl_wr_addr | input | FL_AW | Address of the write attempt |
| rtc_year_roll | input | 1 | Year rollover pulse, slow domain |
| wdt_zero | input | 1 | Watchdog-reached-zero pulse |
| dout_wr | input | 1 | Data-out port register write strobe |
| din_wr | input | 1 | Data-in port register write strobe |
| nmi_redir_sts | input | 1 | Live redirected-NMI status |
| sts_q | output | 16 | Status word |
| smi_n | output | 1 | SMI request, active low |

## Verification
The bench targets a simultaneous set and clear on one bit. A design that gives the clear priority would lose the event. It probes the alias window at both of its ends and just outside each, since an off-by-one compare would either flag a legal alias write or let a real violation through. It holds `prot_en` high after a clear to catch a level-sensitive check that sets the flag over and over. It times the century clear across the slow domain to expose a design that clears too early or never lets go. It also writes ones to the read-only and reserved bits, and times the SMI release, which would show a request that lingers or drops a cycle late.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int unsigned STS_W   = 16;
  localparam int unsigned NMI_B   = 0;
  localparam int unsigned DIN_B   = 1;
  localparam int unsigned DOUT_B  = 2;
  localparam int unsigned WDT_B   = 3;
  localparam int unsigned CEN_B   = 7;
  localparam int unsigned WPV_B   = 8;
  // core-domain write-one-to-clear flags: index 0 watchdog, 1 data-out, 2 data-in, 3 violation
  localparam int unsigned NUM_W1C = 4;
  localparam int unsigned W1C_POS [NUM_W1C] = '{WDT_B, DOUT_B, DIN_B, WPV_B};
  typedef logic [STS_W-1:0] sts_t;
endpackage

// File: rtl/smi_sync.sv
module smi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/smi_w1c_bit.sv
module smi_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set has priority over a same-cycle clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/smi_wprot_chk.sv
module smi_wprot_chk #(
  parameter int unsigned     FL_AW      = 32,
  parameter logic [FL_AW-1:0] ALIAS_BASE = 32'hFF80_0000,
  parameter logic [FL_AW-1:0] ALIAS_SIZE = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_en,
  input  logic             lock_dn,
  input  logic             fl_wr_stb,
  input  logic [FL_AW-1:0] fl_wr_addr,
  output logic             viol_o
);
  logic             prot_q;
  logic             prot_rise;
  logic             in_alias;
  logic [FL_AW-1:0] offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_q <= 1'b0;
    else        prot_q <= prot_en;
  end

  always_comb begin
    offs      = fl_wr_addr - ALIAS_BASE;   // wraps below the base, so one compare suffices
    in_alias  = (offs < ALIAS_SIZE);
    prot_rise = prot_en & ~prot_q & lock_dn;
    viol_o    = prot_rise | (fl_wr_stb & prot_en & ~in_alias);
  end
endmodule

// File: rtl/smi_century_cdc.sv
module smi_century_cdc (
  input  logic clk,
  input  logic rst_n,
  input  logic rtc_clk,
  input  logic rtc_rst_n,
  input  logic roll_rtc,
  input  logic clr_req,
  output logic cen_o
);
  logic clr_tgl;
  logic tgl_s;
  logic tgl_d;
  logic clr_hit;
  logic cen_rtc;

  // core side: every clear request flips a toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       clr_tgl <= 1'b0;
    else if (clr_req) clr_tgl <= ~clr_tgl;
  end

  smi_sync #(.STAGES(2)) u_to_rtc (
    .clk  (rtc_clk),
    .rst_n(rtc_rst_n),
    .d    (clr_tgl),
    .q    (tgl_s)
  );

  always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) tgl_d <= 1'b0;
    else            tgl_d <= tgl_s;
  end

  assign clr_hit = tgl_s ^ tgl_d;

  always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n)    cen_rtc <= 1'b0;
    else if (roll_rtc) cen_rtc <= 1'b1;
    else if (clr_hit)  cen_rtc <= 1'b0;
  end

  smi_sync #(.STAGES(2)) u_to_core (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cen_rtc),
    .q    (cen_o)
  );
endmodule

// File: rtl/smi_evt_collector.sv
module smi_evt_collector
  import smi_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR   = 8'h44,
  parameter int unsigned      FL_AW      = 32,
  parameter logic [FL_AW-1:0]  ALIAS_BASE = 32'hFF80_0000,
  parameter logic [FL_AW-1:0]  ALIAS_SIZE = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_clk,
  input  logic              rtc_rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [STS_W-1:0]  reg_wr_data,
  input  logic              prot_en,
  input  logic              lock_dn,
  input  logic              fl_wr_stb,
  input  logic [FL_AW-1:0]  fl_wr_addr,
  input  logic              rtc_year_roll,
  input  logic              wdt_zero,
  input  logic              dout_wr,
  input  logic              din_wr,
  input  logic              nmi_redir_sts,
  output logic [STS_W-1:0]  sts_q,
  output logic              smi_n
);
  sts_t               clr_mask;
  logic [NUM_W1C-1:0] set_vec;
  logic [NUM_W1C-1:0] w1c_q;
  logic               viol_set;
  logic               cen_q;
  logic               nmi_q;
  logic               smi_n_q;
  logic               unused_wdata;

  assign clr_mask     = (reg_wr_en && (reg_wr_addr == STS_ADDR)) ? reg_wr_data : '0;
  assign unused_wdata = ^{clr_mask[NMI_B], clr_mask[6:4], clr_mask[STS_W-1:WPV_B+1]};

  smi_wprot_chk #(
    .FL_AW     (FL_AW),
    .ALIAS_BASE(ALIAS_BASE),
    .ALIAS_SIZE(ALIAS_SIZE)
  ) u_wprot (
    .clk       (clk),
    .rst_n     (rst_n),
    .prot_en   (prot_en),
    .lock_dn   (lock_dn),
    .fl_wr_stb (fl_wr_stb),
    .fl_wr_addr(fl_wr_addr),
    .viol_o    (viol_set)
  );

  assign set_vec = {viol_set, din_wr, dout_wr, wdt_zero};

  for (genvar gi = 0; gi < NUM_W1C; gi++) begin : g_w1c
    smi_w1c_bit u_bit (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_vec[gi]),
      .clr_i(clr_mask[W1C_POS[gi]]),
      .q_o  (w1c_q[gi])
    );
  end

  smi_century_cdc u_cen (
    .clk      (clk),
    .rst_n    (rst_n),
    .rtc_clk  (rtc_clk),
    .rtc_rst_n(rtc_rst_n),
    .roll_rtc (rtc_year_roll),
    .clr_req  (clr_mask[CEN_B]),
    .cen_o    (cen_q)
  );

  // read-only mirror of the external redirected-NMI status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= nmi_redir_sts;
  end

  always_comb begin
    sts_q        = '0;
    sts_q[NMI_B] = nmi_q;
    sts_q[CEN_B] = cen_q;
    for (int i = 0; i < NUM_W1C; i++) begin
      sts_q[W1C_POS[i]] = w1c_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_n_q <= 1'b1;
    else        smi_n_q <= ~(|sts_q);
  end

  assign smi_n = smi_n_q;
endmodule

// File: rtl/smi_evt_collector_chk.sv
module smi_evt_collector_chk
  import smi_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR   = 8'h44,
  parameter int unsigned      FL_AW      = 32,
  parameter logic [FL_AW-1:0]  ALIAS_BASE = 32'hFF80_0000,
  parameter logic [FL_AW-1:0]  ALIAS_SIZE = 32'h0040_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_addr,
  input logic [STS_W-1:0]  reg_wr_data,
  input logic              prot_en,
  input logic              lock_dn,
  input logic              fl_wr_stb,
  input logic [FL_AW-1:0]  fl_wr_addr,
  input logic              wdt_zero,
  input logic              din_wr,
  input logic              nmi_redir_sts,
  input logic [STS_W-1:0]  sts_q,
  input logic              smi_n
);
  logic hit;
  logic alias_win;

  assign hit       = reg_wr_en && (reg_wr_addr == STS_ADDR);
  assign alias_win = (fl_wr_addr >= ALIAS_BASE) && ((fl_wr_addr - ALIAS_BASE) < ALIAS_SIZE);

  a_r12_smi_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q != '0) |=> !smi_n);

  a_r12_smi_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q == '0) |=> smi_n);

  a_r2_wdt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_zero |=> sts_q[WDT_B]);

  a_r2_wdt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[WDT_B] && !(hit && reg_wr_data[WDT_B])) |=> sts_q[WDT_B]);

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (din_wr && hit && reg_wr_data[DIN_B]) |=> sts_q[DIN_B]);

  a_r10_nmi_high: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_redir_sts |=> sts_q[NMI_B]);

  a_r10_nmi_low: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_redir_sts |=> !sts_q[NMI_B]);

  a_r5_prot_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr_stb && prot_en && !alias_win) |=> sts_q[WPV_B]);

  a_r6_alias_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr_stb && alias_win && !lock_dn && !sts_q[WPV_B]) |=> !sts_q[WPV_B]);
endmodule

bind smi_evt_collector smi_evt_collector_chk #(
  .ADDR_W    (ADDR_W),
  .STS_ADDR  (STS_ADDR),
  .FL_AW     (FL_AW),
  .ALIAS_BASE(ALIAS_BASE),
  .ALIAS_SIZE(ALIAS_SIZE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_wr_addr  (reg_wr_addr),
  .reg_wr_data  (reg_wr_data),
  .prot_en      (prot_en),
  .lock_dn      (lock_dn),
  .fl_wr_stb    (fl_wr_stb),
  .fl_wr_addr   (fl_wr_addr),
  .wdt_zero     (wdt_zero),
  .din_wr       (din_wr),
  .nmi_redir_sts(nmi_redir_sts),
  .sts_q        (sts_q),
  .smi_n        (smi_n)
);

// File: tb/smi_evt_collector_bench.sv
module smi_evt_collector_bench;
  localparam int CLK_P  = 10;
  localparam int RTC_P  = 74;
  localparam logic [7:0] SA = 8'h44;

  logic        clk = 1'b0;
  logic        rtc_clk = 1'b0;
  logic        rst_n, rtc_rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_addr;
  logic [15:0] reg_wr_data;
  logic        prot_en, lock_dn, fl_wr_stb;
  logic [31:0] fl_wr_addr;
  logic        rtc_year_roll, wdt_zero, dout_wr, din_wr, nmi_redir_sts;
  logic [15:0] sts_q;
  logic        smi_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always #(RTC_P/2) rtc_clk = ~rtc_clk;

  smi_evt_collector u_smi_evt_collector (
    .clk(clk), .rst_n(rst_n), .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .prot_en(prot_en), .lock_dn(lock_dn), .fl_wr_stb(fl_wr_stb), .fl_wr_addr(fl_wr_addr),
    .rtc_year_roll(rtc_year_roll), .wdt_zero(wdt_zero), .dout_wr(dout_wr), .din_wr(din_wr),
    .nmi_redir_sts(nmi_redir_sts), .sts_q(sts_q), .smi_n(smi_n)
  );

  typedef struct packed {
    logic        wdt;
    logic        din;
    logic        dout;
    logic        wr;
    logic [15:0] wdata;
    logic        nmi;
    logic [15:0] exp_sts;
    logic        exp_smi;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0008, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0008, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0004, 1'b0, 16'h0008, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0008, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0002, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0006, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 16'h0002, 1'b0, 16'h0006, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0006, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0001, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0001, 1'b1, 16'h0001, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b0, 16'h0008, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    cyc();
    reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  task automatic flw(input logic [31:0] a);
    fl_wr_stb = 1'b1; fl_wr_addr = a;
    cyc();
    fl_wr_stb = 1'b0;
  endtask

  task automatic roll();
    @(negedge rtc_clk); rtc_year_roll = 1'b1;
    @(negedge rtc_clk); rtc_year_roll = 1'b0;
    @(negedge clk);
    repeat (3) cyc();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rtc_rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_wr_addr = SA; reg_wr_data = '0;
    prot_en = 1'b0; lock_dn = 1'b0; fl_wr_stb = 1'b0; fl_wr_addr = '0;
    rtc_year_roll = 1'b0; wdt_zero = 1'b0; dout_wr = 1'b0; din_wr = 1'b0;
    nmi_redir_sts = 1'b0;
    repeat (5) cyc();
    rst_n = 1'b1; rtc_rst_n = 1'b1;
    cyc();
    chk("R1 status after reset", {16'h0, sts_q}, 32'h0);
    chk("R1 smi after reset", {31'h0, smi_n}, 32'h1);

    // table walk: R2 R3 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      wdt_zero = VEC[i].wdt; din_wr = VEC[i].din; dout_wr = VEC[i].dout;
      reg_wr_en = VEC[i].wr; reg_wr_addr = SA; reg_wr_data = VEC[i].wdata;
      nmi_redir_sts = VEC[i].nmi;
      cyc();
      wdt_zero = 1'b0; din_wr = 1'b0; dout_wr = 1'b0; reg_wr_en = 1'b0;
      chk($sformatf("R2/R3/R10/R11 table row %0d sts", i), {16'h0, sts_q}, {16'h0, VEC[i].exp_sts});
      chk($sformatf("R12 table row %0d smi", i), {31'h0, smi_n}, {31'h0, VEC[i].exp_smi});
    end

    // R2: a write to another address leaves the flag set
    wdt_zero = 1'b1; cyc(); wdt_zero = 1'b0;
    wr(8'h45, 16'h0008);
    chk("R2 wrong address keeps bit3", {16'h0, sts_q}, 32'h0008);
    wr(SA, 16'h0008);
    chk("R2 clear bit3", {16'h0, sts_q}, 32'h0);

    // R4: protect-enable rise
    prot_en = 1'b1; cyc();
    chk("R4 rise without lock", {16'h0, sts_q}, 32'h0);
    prot_en = 1'b0; lock_dn = 1'b1; cyc();
    prot_en = 1'b1; cyc();
    chk("R4 rise with lock sets bit8", {16'h0, sts_q}, 32'h0100);
    wr(SA, 16'h0100);
    cyc();
    chk("R4 held level does not re-set", {16'h0, sts_q}, 32'h0);
    lock_dn = 1'b0;

    // R5: protected write attempts outside the alias window
    flw(32'hFFFF_0000);
    chk("R5 protected write sets bit8", {16'h0, sts_q}, 32'h0100);
    wr(SA, 16'h0100);
    flw(32'hFFC0_0000);
    chk("R5 first address above window sets", {16'h0, sts_q}, 32'h0100);
    wr(SA, 16'h0100);
    prot_en = 1'b0; cyc();
    flw(32'hFFFF_0000);
    chk("R5 unprotected write ignored", {16'h0, sts_q}, 32'h0);

    // R6: alias window edges
    prot_en = 1'b1; cyc();
    flw(32'hFF80_0000);
    chk("R6 alias low edge ignored", {16'h0, sts_q}, 32'h0);
    flw(32'hFFBF_FFFF);
    chk("R6 alias high edge ignored", {16'h0, sts_q}, 32'h0);
    flw(32'hFF7F_FFFF);
    chk("R6 below alias sets", {16'h0, sts_q}, 32'h0100);
    wr(SA, 16'h0100);
    prot_en = 1'b0; cyc();

    // R7: century set through the slow domain
    roll();
    chk("R7 century visible", {16'h0, sts_q}, 32'h0080);
    chk("R12 smi low for century", {31'h0, smi_n}, 32'h0);

    // R8: century clear latency
    wr(SA, 16'h0080);
    chk("R8 century still set next cycle", {16'h0, sts_q}, 32'h0080);
    repeat (26) cyc();
    chk("R8 century cleared after slow clocks", {16'h0, sts_q}, 32'h0);
    cyc();
    chk("R12 smi released", {31'h0, smi_n}, 32'h1);

    // R9: slow-domain reset clears century
    roll();
    chk("R9 century set before reset", {16'h0, sts_q}, 32'h0080);
    @(negedge rtc_clk); rtc_rst_n = 1'b0;
    @(negedge clk);
    repeat (3) cyc();
    chk("R9 century cleared by slow reset", {16'h0, sts_q}, 32'h0);
    @(negedge rtc_clk); rtc_rst_n = 1'b1;
    @(negedge clk);
    repeat (4) cyc();
    chk("R9 century stays clear", {16'h0, sts_q}, 32'h0);

    // R11: reserved bits under an all-ones write with everything set
    nmi_redir_sts = 1'b1; wdt_zero = 1'b1; din_wr = 1'b1; dout_wr = 1'b1; cyc();
    wdt_zero = 1'b0; din_wr = 1'b0; dout_wr = 1'b0;
    chk("R11 reserved zero with flags set", {16'h0, sts_q & 16'hFE70}, 32'h0);
    wr(SA, 16'hFFFF);
    chk("R10 read-only bit survives clear", {16'h0, sts_q}, 32'h0001);
    nmi_redir_sts = 1'b0; cyc();
    chk("R10 bit0 follows input", {16'h0, sts_q}, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule